// File: doc/BRIEF.md
# Cascadable BCD Up/Down Counter

A single decimal digit counter that steps once per rising clock edge, upward or downward as the direction input selects. An active-low count enable freezes the digit. The carry output is active low and purely combinational, which lets digits be chained on one shared clock: the carry output of each digit feeds the enable of the next one up. The upper digit then steps exactly once per full ten-count cycle of the digit below it, and no carry passes through a register between them.

Two asynchronous controls override the clock. A low on `rst_ni` clears the digit at once. A high on `load_i` copies `preset_i` into the digit at once. Both hold the digit for as long as they stay asserted, and reset wins over load. Codes 10 to 15 can only enter the register through the preset path. Any enabled clock edge turns such a code back into a valid digit.

Top module: `bcd_updown_ctr`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0. The clear takes effect without waiting for a clock edge and has priority over `load_i`.
- R2: While `rst_ni` is high and `load_i` is high, `count_o` takes the value of `preset_i` without waiting for a clock edge. Clock edges during this time load `preset_i` again and never count.
- R3: While `carry_ni` is high, and neither reset nor load is active, rising clock edges leave `count_o` unchanged.
- R4: When `up_i` is 1 and `carry_ni` is 0, a rising edge moves a count of 0 to 8 up by one and moves 9 to 0.
- R5: When `up_i` is 0 and `carry_ni` is 0, a rising edge moves a count of 1 to 9 down by one and moves 0 to 9.
- R6: When `up_i` is 1, `carry_no` is 0 exactly when `count_o` bit 0 and bit 3 are both 1 and `carry_ni` is 0. Otherwise it is 1.
- R7: When `up_i` is 0, `carry_no` is 0 exactly when `count_o` is 0 and `carry_ni` is 0. Otherwise it is 1. `carry_no` follows changes on `carry_ni` and `up_i` within the same cycle, with no clock edge involved.
- R8: With `carry_ni` at 0, a code from 10 to 15 becomes 0 on the next rising edge when `up_i` is 1, and becomes 9 when `up_i` is 0.
- R9: With `carry_no` of a lower digit wired to `carry_ni` of an upper digit, and both on a common clock, the pair counts modulo 100 in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; counting happens on its rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| carry_ni | input | 1 | Count enable, active low; from the lower digit's carry |
| load_i | input | 1 | Asynchronous preset, active high |
| preset_i | input | 4 | Value loaded while `load_i` is high |
| count_o | output | 4 | Current digit, bit 0 least significant |
| carry_no | output | 1 | Active-low terminal-count carry to the next digit |

## Verification
The assertions assume three things about the inputs. `preset_i` does not change between clock edges while `load_i` stays high. `load_i` and `rst_ni` never change at a rising edge. The count is judged only at edges with no asynchronous control active. The bench changes every input on the falling clock edge, or a nanosecond after it, so releases behave like synchronous signals and no removal window is ever crossed. It also presents each new preset value together with the rising edge of `load_i`.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int unsigned DIG_W   = 4;
  localparam int unsigned DIG_MAX = 9;
  typedef logic [DIG_W-1:0] digit_t;
endpackage

// File: rtl/bcd_step.sv
module bcd_step
  import bcd_ctr_pkg::*;
(
  input  digit_t cur_i,
  input  logic   up_i,
  output digit_t nxt_o
);
  localparam digit_t TOP  = digit_t'(DIG_MAX);
  localparam digit_t ZERO = '0;
  localparam digit_t ONE  = digit_t'(1);

  always_comb begin
    if (up_i) begin
      // 9 and every illegal code fold to zero
      nxt_o = (cur_i >= TOP) ? ZERO : cur_i + ONE;
    end else begin
      // zero and every illegal code fold to the top digit
      nxt_o = (cur_i == ZERO || cur_i > TOP) ? TOP : cur_i - ONE;
    end
  end
endmodule

// File: rtl/bcd_carry_dec.sv
module bcd_carry_dec
  import bcd_ctr_pkg::*;
(
  input  digit_t cur_i,
  input  logic   up_i,
  input  logic   carry_ni,
  output logic   carry_no
);
  logic term_up, term_dn, term;

  // sparse decode: only bits 0 and MSB matter going up
  assign term_up  = cur_i[0] & cur_i[DIG_W-1];
  assign term_dn  = ~|cur_i;
  assign term     = up_i ? term_up : term_dn;
  assign carry_no = ~(term & ~carry_ni);
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
  import bcd_ctr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  digit_t preset_i,
  input  logic   en_i,
  input  digit_t nxt_i,
  output digit_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge load_i) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= preset_i;
    else if (en_i)   q_o <= nxt_i;
  end
endmodule

// File: rtl/bcd_updown_ctr.sv
module bcd_updown_ctr
  import bcd_ctr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             carry_ni,
  input  logic             load_i,
  input  logic [DIG_W-1:0] preset_i,
  output logic [DIG_W-1:0] count_o,
  output logic             carry_no
);
  digit_t cur, nxt;

  bcd_step u_step (
    .cur_i (cur),
    .up_i  (up_i),
    .nxt_o (nxt)
  );

  bcd_state_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .preset_i (preset_i),
    .en_i     (~carry_ni),
    .nxt_i    (nxt),
    .q_o      (cur)
  );

  bcd_carry_dec u_carry (
    .cur_i    (cur),
    .up_i     (up_i),
    .carry_ni (carry_ni),
    .carry_no (carry_no)
  );

  assign count_o = cur;
endmodule

// File: rtl/bcd_updown_ctr_chk.sv
module bcd_updown_ctr_chk
  import bcd_ctr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             up_i,
  input logic             carry_ni,
  input logic             load_i,
  input logic [DIG_W-1:0] preset_i,
  input logic [DIG_W-1:0] count_o,
  input logic             carry_no
);
  a_r2_load_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!load_i || count_o == $past(preset_i)));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_ni && !load_i) |=> (load_i || $stable(count_o)));

  a_r4_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_ni && !load_i && up_i && count_o < 4'd9)
      |=> (load_i || count_o == $past(count_o) + 4'd1));

  a_r4_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_ni && !load_i && up_i && count_o == 4'd9) |=> (load_i || count_o == 4'd0));

  a_r5_dn_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_ni && !load_i && !up_i && count_o != 4'd0 && count_o <= 4'd9)
      |=> (load_i || count_o == $past(count_o) - 4'd1));

  a_r5_dn_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_ni && !load_i && !up_i && count_o == 4'd0) |=> (load_i || count_o == 4'd9));

  a_r6_carry_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !carry_no) |-> (!carry_ni && count_o inside {4'd9, 4'd11, 4'd13, 4'd15}));

  a_r7_carry_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && !carry_no) |-> (!carry_ni && count_o == 4'd0));

  a_r8_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_ni && !load_i && count_o > 4'd9) |=> (load_i || count_o <= 4'd9));
endmodule

bind bcd_updown_ctr bcd_updown_ctr_chk u_chk (.*);

// File: tb/sim_bcd_updown_ctr.sv
`timescale 1ns/1ps
module sim_bcd_updown_ctr;
  logic clk = 1'b0;
  logic rst_n, up, cin_n, load0, load1;
  logic [3:0] pre0, pre1, cnt0, cnt1;
  logic co0_n, co1_n;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_updown_ctr u0 (.clk_i(clk), .rst_ni(rst_n), .up_i(up), .carry_ni(cin_n),
    .load_i(load0), .preset_i(pre0), .count_o(cnt0), .carry_no(co0_n));
  bcd_updown_ctr u1 (.clk_i(clk), .rst_ni(rst_n), .up_i(up), .carry_ni(co0_n),
    .load_i(load1), .preset_i(pre1), .count_o(cnt1), .carry_no(co1_n));

  task automatic chk(input string req, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #2;
  endtask

  function automatic int nxt(int v, int d);
    if (d != 0) return (v >= 9) ? 0 : v + 1;
    return (v == 0 || v > 9) ? 9 : v - 1;
  endfunction

  function automatic int exp_co(int v, int d, int c);
    if (c != 0) return 1;
    if (d != 0) return ((v % 2 == 1) && (v >= 8)) ? 0 : 1;
    return (v == 0) ? 0 : 1;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog got 0 exp 1");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int e, t;
    rst_n = 0; up = 1; cin_n = 1; load0 = 0; load1 = 0; pre0 = 0; pre1 = 0;
    #3 chk("R1 reset value", cnt0, 0);
    @(negedge clk) rst_n = 1;

    // sweep every code, direction and enable
    for (int v = 0; v < 16; v++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++) begin
          @(negedge clk); pre0 = 4'(v); load0 = 1; up = 1'(d); cin_n = 0;
          #1 chk("R2 async load", cnt0, v);
          tick; chk("R2 load blocks count", cnt0, v);
          @(negedge clk); load0 = 0; cin_n = 1'(c);
          #1 chk(d ? "R6 carry" : "R7 carry", co0_n, exp_co(v, d, c));
          cin_n = ~1'(c);
          #1 chk("R7 carry same cycle", co0_n, exp_co(v, d, 1 - c));
          cin_n = 1'(c);
          #1;
          tick;
          e = c ? v : nxt(v, d);
          if (c) chk("R3 hold", cnt0, e);
          else if (v > 9) chk("R8 recover", cnt0, e);
          else chk(d ? "R4 up" : "R5 down", cnt0, e);
          tick;
          e = c ? e : nxt(e, d);
          chk(d ? "R4 up second" : "R5 down second", cnt0, e);
        end

    // reset mid-cycle over an active load
    @(negedge clk); pre0 = 4'd7; load0 = 1;
    #1 rst_n = 0;
    #1 chk("R1 overrides load", cnt0, 0);
    tick; chk("R1 holds", cnt0, 0);
    @(negedge clk); rst_n = 1; load0 = 0; cin_n = 1;
    tick; chk("R1 after release", cnt0, 0);

    // two-digit cascade
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; up = 1; cin_n = 0;
    t = 0;
    for (int n = 0; n < 120; n++) begin
      tick; t = (t + 1) % 100;
      chk("R9 units up", cnt0, t % 10);
      chk("R9 tens up", cnt1, t / 10);
    end
    @(negedge clk); up = 0;
    for (int n = 0; n < 130; n++) begin
      tick; t = (t + 99) % 100;
      chk("R9 units down", cnt0, t % 10);
      chk("R9 tens down", cnt1, t / 10);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule